// File: doc/BRIEF.md
# SDRAM Command Front End with Mode Registers

This block is the device-side command decoder of a double-data-rate SDRAM model. On every rising clock edge it samples an active-low chip select, the three active-low command strobes (row strobe, column strobe, write enable), a two-bit bank number and a 13-bit address bus. It decodes bank activate, single-bank and all-bank precharge, read, and writes to a base mode register and an extended mode register. It tracks which of the four banks hold an open row.

The decoded register fields drive the rest of the model: burst length, addressing mode, read latency, DLL disable, weak output drive and the external switch-control enable. A two-cycle busy window follows each accepted register write. A lock countdown follows each DLL enable or DLL reset, and it gates reads. Illegal sequences produce a one-cycle protocol-violation pulse, and a test-mode request produces a one-cycle error pulse. Data movement, refresh and the storage array belong to other blocks.

Top module: `sdram_cmd_front`

## Requirements
- R1: When `cs_n` is sampled high, the sampled command has no effect: bank state, register fields and both error flags stay unchanged.
- R2: Activate ({cs_n,ras_n,cas_n,we_n}=0011) marks bank `ba` open in `bank_open` one clock later.
- R3: Precharge (0010) with `addr[10]`=0 closes only bank `ba`. With `addr[10]`=1 it closes all four banks.
- R4: A register write is code 0000. With `ba[0]`=0 it loads the base register: `burst_len`=addr[2:0], `addr_mode`=addr[3], `cas_lat`=addr[6:4]. With addr[8]=1 it also restarts the DLL lock countdown.
- R5: With `ba[0]`=1, a register write loads the extended register: `dll_off`=addr[0] (0 means enabled), `weak_drive`=addr[1], `fet_ctl_en`=addr[2]. With addr[0]=0 it restarts the lock countdown.
- R6: A register write while any bank is open is rejected. Registers keep their values and `proto_err` pulses high for one cycle after the command.
- R7: A base register write with addr[7]=1 is rejected. `test_err` pulses for one cycle and the base fields stay unchanged.
- R8: An accepted register write raises `busy` for the next cycle. A command sampled while `busy` is high is ignored and pulses `proto_err`.
- R9: `dll_locked` goes high exactly 200 clocks after the edge that started the countdown, provided the DLL is enabled. A DLL disable drops it at once.
- R10: A read (0101) when `dll_locked` is low or bank `ba` is closed pulses `proto_err`. A read to an open bank with the DLL locked does not.
- R11: After reset, all banks are closed, the base fields are zero, `dll_off`=1, and `weak_drive`, `fet_ctl_en`, `busy`, `dll_locked`, `proto_err` and `test_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank number; bit 0 also selects the register |
| addr | input | 13 | Address / register operand |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| burst_len | output | 3 | Base register burst-length code |
| addr_mode | output | 1 | Base register addressing mode |
| cas_lat | output | 3 | Base register read-latency code |
| dll_off | output | 1 | Extended register DLL disable |
| weak_drive | output | 1 | Extended register weak drive select |
| fet_ctl_en | output | 1 | Extended register switch-control output enable |
| busy | output | 1 | Register write completing; commands ignored |
| dll_locked | output | 1 | DLL enabled and lock countdown finished |
| proto_err | output | 1 | One-cycle protocol violation pulse |
| test_err | output | 1 | One-cycle test-mode rejection pulse |

## Verification
The hardest state to reach from the ports is a locked DLL together with an open bank. It is the only condition in which a read is legal. It requires an extended write with every bank idle, then the full countdown, and only then an activate. The bench reaches it in that order. It samples `dll_locked` one cycle before and exactly at the end of the countdown, and then follows with a legal read and a read to a closed bank. The busy window is probed by placing an activate directly behind a register write.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_MODE,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_OTHER
  } cmd_e;

  // strobes are active low: {cs_n, ras_n, cas_n, we_n}
  function automatic cmd_e decode_cmd(input logic [3:0] strb);
    case (strb)
      4'b0000: decode_cmd = CMD_MODE;
      4'b0011: decode_cmd = CMD_ACT;
      4'b0010: decode_cmd = CMD_PRE;
      4'b0101: decode_cmd = CMD_RD;
      4'b0100: decode_cmd = CMD_WR;
      4'b0111: decode_cmd = CMD_NOP;
      default: decode_cmd = strb[3] ? CMD_NOP : CMD_OTHER;
    endcase
  endfunction

  function automatic logic count_done(input int unsigned cnt);
    count_done = (cnt == 0);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       busy,
  output cmd_e       cmd,
  output logic       blocked
);

  cmd_e raw;

  always_comb begin
    raw     = decode_cmd({cs_n, ras_n, cas_n, we_n});
    blocked = busy && (raw != CMD_NOP);
    cmd     = busy ? CMD_NOP : raw;
  end

  always_comb begin
    assert_deselect_nop_R1: assert (!(cs_n === 1'b1) || cmd == CMD_NOP);
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_en,
  input  logic                 pre_en,
  input  logic                 pre_all,
  input  logic [BANK_BITS-1:0] bank,
  output logic [NUM_BANKS-1:0] open_q
);

  logic [NUM_BANKS-1:0] sel;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign sel[b] = (bank == BANK_BITS'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             open_q[b] <= 1'b0;
        else if (act_en && sel[b])              open_q[b] <= 1'b1;
        else if (pre_en && (pre_all || sel[b])) open_q[b] <= 1'b0;
      end
    end
  endgenerate

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> open_q[$past(bank)]);
  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && pre_all) |=> (open_q == '0));
  assert_pre_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !pre_all) |=> !open_q[$past(bank)]);

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 200,
  parameter int MRD_CYCLES  = 2,
  localparam int LCW = $clog2(LOCK_CYCLES + 1),
  localparam int BCW = $clog2(MRD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_ext,
  input  logic [ADDR_W-1:0] opnd,
  output logic [2:0]        burst_len,
  output logic              addr_mode,
  output logic [2:0]        cas_lat,
  output logic              dll_off,
  output logic              weak_drive,
  output logic              fet_ctl_en,
  output logic              busy,
  output logic              dll_locked
);

  logic [LCW-1:0] lock_cnt;
  logic [BCW-1:0] busy_cnt;
  logic           lock_start;

  assign lock_start = (wr_ext && !opnd[0]) || (wr_base && opnd[8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_len <= '0;
      addr_mode <= 1'b0;
      cas_lat   <= '0;
    end else if (wr_base) begin
      burst_len <= opnd[2:0];
      addr_mode <= opnd[3];
      cas_lat   <= opnd[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_off    <= 1'b1;
      weak_drive <= 1'b0;
      fet_ctl_en <= 1'b0;
    end else if (wr_ext) begin
      dll_off    <= opnd[0];
      weak_drive <= opnd[1];
      fet_ctl_en <= opnd[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lock_cnt <= '0;
    else if (wr_ext && opnd[0])      lock_cnt <= '0;
    else if (lock_start)             lock_cnt <= LCW'(LOCK_CYCLES);
    else if (!count_done(lock_cnt))  lock_cnt <= lock_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_cnt <= '0;
    else if (wr_base || wr_ext)      busy_cnt <= BCW'(MRD_CYCLES - 1);
    else if (!count_done(busy_cnt))  busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy       = !count_done(busy_cnt);
  assign dll_locked = !dll_off && count_done(lock_cnt);

  assert_no_write_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wr_base || wr_ext));
  assert_write_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base || wr_ext) |=> busy);
  assert_lock_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> !dll_locked);
  assert_no_test_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |-> !opnd[7]);

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_BITS   = 2,
  parameter int LOCK_CYCLES = 200,
  parameter int MRD_CYCLES  = 2,
  parameter int PRE_ALL_BIT = 10,
  localparam int NUM_BANKS  = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [2:0]           burst_len,
  output logic                 addr_mode,
  output logic [2:0]           cas_lat,
  output logic                 dll_off,
  output logic                 weak_drive,
  output logic                 fet_ctl_en,
  output logic                 busy,
  output logic                 dll_locked,
  output logic                 proto_err,
  output logic                 test_err
);

  cmd_e cmd;
  logic blocked;
  logic any_open;
  logic mode_try, mode_busy_bank, mode_test;
  logic wr_base, wr_ext;
  logic rd_bad;
  logic proto_d, test_d;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .busy(busy), .cmd(cmd), .blocked(blocked)
  );

  assign any_open       = |bank_open;
  assign mode_try       = (cmd == CMD_MODE);
  assign mode_busy_bank = mode_try && any_open;
  assign mode_test      = mode_try && !any_open && !ba[0] && addr[7];
  assign wr_base        = mode_try && !any_open && !ba[0] && !addr[7];
  assign wr_ext         = mode_try && !any_open && ba[0];
  assign rd_bad         = (cmd == CMD_RD) && (!dll_locked || !bank_open[ba]);
  assign proto_d        = blocked || mode_busy_bank || rd_bad;
  assign test_d         = mode_test;

  sdram_bank_track #(.BANK_BITS(BANK_BITS)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(cmd == CMD_ACT), .pre_en(cmd == CMD_PRE),
    .pre_all(addr[PRE_ALL_BIT]), .bank(ba), .open_q(bank_open)
  );

  sdram_mode_regs #(
    .ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK_CYCLES), .MRD_CYCLES(MRD_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_base(wr_base), .wr_ext(wr_ext), .opnd(addr),
    .burst_len(burst_len), .addr_mode(addr_mode), .cas_lat(cas_lat),
    .dll_off(dll_off), .weak_drive(weak_drive), .fet_ctl_en(fet_ctl_en),
    .busy(busy), .dll_locked(dll_locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_err <= 1'b0;
      test_err  <= 1'b0;
    end else begin
      proto_err <= proto_d;
      test_err  <= test_d;
    end
  end

  assert_open_rejects_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !cas_n && !we_n && !busy && any_open)
      |=> proto_err && $stable(burst_len) && $stable(dll_off) && $stable(cas_lat));
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !busy) |=> $stable(bank_open) && !proto_err && !test_err);
  assert_test_unchanged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_err |-> $stable(burst_len) && $stable(cas_lat) && $stable(addr_mode));
  assert_bad_read_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && we_n && !busy && !dll_locked) |=> proto_err);

endmodule

// File: tb/sim_sdram_cmd_front.sv
module sim_sdram_cmd_front;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_open;
  logic [2:0]  burst_len, cas_lat;
  logic        addr_mode, dll_off, weak_drive, fet_ctl_en, busy, dll_locked;
  logic        proto_err, test_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
    .burst_len(burst_len), .addr_mode(addr_mode), .cas_lat(cas_lat),
    .dll_off(dll_off), .weak_drive(weak_drive), .fet_ctl_en(fet_ctl_en),
    .busy(busy), .dll_locked(dll_locked), .proto_err(proto_err), .test_err(test_err)
  );

  // {cs,ras,cas,we}[23:20] ba[19:18] addr[17:5] expected banks[4:1] expected proto[0]
  localparam logic [23:0] VEC [NVEC] = '{
    {4'b0011, 2'd0, 13'h0000, 4'b0001, 1'b0},  // R2 activate bank 0
    {4'b0011, 2'd2, 13'h0000, 4'b0101, 1'b0},  // R2 activate bank 2
    {4'b1011, 2'd1, 13'h0000, 4'b0101, 1'b0},  // R1 deselected activate
    {4'b0010, 2'd0, 13'h0000, 4'b0100, 1'b0},  // R3 single precharge
    {4'b0000, 2'd0, 13'h002B, 4'b0100, 1'b1},  // R6 register write, bank open
    {4'b0101, 2'd2, 13'h0000, 4'b0100, 1'b1},  // R10 read, DLL not locked
    {4'b0010, 2'd0, 13'h0400, 4'b0000, 1'b0},  // R3 precharge all
    {4'b0111, 2'd0, 13'h0000, 4'b0000, 1'b0}   // no operation
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capturing edge
  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    ba = '0;
    addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R11 reset state
    chk("R11 bank_open", int'(bank_open), 0);
    chk("R11 dll_off", int'(dll_off), 1);
    chk("R11 dll_locked", int'(dll_locked), 0);
    chk("R11 busy", int'(busy), 0);
    chk("R11 burst_len", int'(burst_len), 0);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][23:20], VEC[i][19:18], VEC[i][17:5]);
      chk($sformatf("vector %0d banks (R1/R2/R3)", i), int'(bank_open), int'(VEC[i][4:1]));
      chk($sformatf("vector %0d proto (R6/R10)", i), int'(proto_err), int'(VEC[i][0]));
    end
    chk("R6 base unchanged", int'(burst_len), 0);

    // R4 base write accepted, R8 busy window
    issue(4'b0000, 2'd0, 13'h002B);
    chk("R8 busy after write", int'(busy), 1);
    chk("R4 burst_len", int'(burst_len), 3);
    chk("R4 addr_mode", int'(addr_mode), 1);
    chk("R4 cas_lat", int'(cas_lat), 2);
    issue(4'b0011, 2'd1, 13'h0000);
    chk("R8 ignored activate", int'(bank_open), 0);
    chk("R8 proto when busy", int'(proto_err), 1);
    chk("R8 busy cleared", int'(busy), 0);

    // R7 test mode rejected
    issue(4'b0000, 2'd0, 13'h00C5);
    chk("R7 test_err", int'(test_err), 1);
    chk("R7 burst_len kept", int'(burst_len), 3);
    chk("R7 busy not set", int'(busy), 0);
    idle(1);
    chk("R7 test_err pulse ends", int'(test_err), 0);

    // R5 extended write enables DLL, R9 countdown
    issue(4'b0000, 2'd1, 13'h0006);
    chk("R5 dll_off", int'(dll_off), 0);
    chk("R5 weak_drive", int'(weak_drive), 1);
    chk("R5 fet_ctl_en", int'(fet_ctl_en), 1);
    chk("R5 base untouched", int'(cas_lat), 2);
    idle(199);
    chk("R9 not locked at 199", int'(dll_locked), 0);
    idle(1);
    chk("R9 locked at 200", int'(dll_locked), 1);

    // R10 legal read and read to a closed bank
    issue(4'b0011, 2'd3, 13'h0000);
    chk("R2 bank 3 open", int'(bank_open), 8);
    issue(4'b0101, 2'd3, 13'h0000);
    chk("R10 legal read", int'(proto_err), 0);
    issue(4'b0101, 2'd0, 13'h0000);
    chk("R10 closed bank read", int'(proto_err), 1);

    // R1 deselected precharge all leaves bank 3 open
    issue(4'b1010, 2'd0, 13'h0400);
    chk("R1 deselect precharge", int'(bank_open), 8);
    issue(4'b0010, 2'd3, 13'h0000);
    chk("R3 close bank 3", int'(bank_open), 0);

    // R4 DLL reset via base register restarts countdown
    issue(4'b0000, 2'd0, 13'h012B);
    chk("R4 dll reset unlocks", int'(dll_locked), 0);
    idle(200);
    chk("R9 relock after reset", int'(dll_locked), 1);

    // R9 disable drops lock
    issue(4'b0000, 2'd1, 13'h0001);
    chk("R9 disable dll_off", int'(dll_off), 1);
    chk("R9 disable unlocks", int'(dll_locked), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule